// File: doc/BRIEF.md
# Predecoded Row Wordline Decoder

This block converts a row address into a one-hot vector of wordline enables for a memory array. It does not build one wide AND term per wordline. The address is first split into small fields, and each field is decoded by its own small predecoder. Each final wordline gate then ANDs together one output from every predecoder. Many wordlines share each predecoder output, which keeps the fan-in of the final gates low.

The grouping is fixed when the block is built. With 4-bit fields, two 4-to-16 predecoders feed 2-input final gates. With 2-bit fields, four 2-to-4 predecoders feed 4-input final gates. Both groupings give the same mapping from address to wordline as a plain full-width decoder. A decode enable gates every predecoder, so all wordlines can be held low. The wordline vector is registered, so it follows the address and the enable one clock later.

Top module: `rowdec_wl_top`

## Requirements
- R1: When `dec_en` is 1 at a rising clock edge, after that edge `wordline` has bit number `row_addr` set, where `row_addr` is the value sampled at that edge.
- R2: `wordline` never has more than one bit set.
- R3: When `dec_en` is 0 at a rising clock edge, `wordline` is all zeros after that edge, whatever the address.
- R4: With `PREDEC_BITS` = 4, address bits [3:0] select one of 16 low predecoder lines and bits [7:4] select one of 16 high predecoder lines. Wordline k is the AND of low line (k mod 16) and high line (k div 16). For example, address 254 drives only wordline 254, and address 255 drives only wordline 255.
- R5: With `PREDEC_BITS` = 2, the bit pairs [1:0], [3:2], [5:4] and [7:6] each select one of 4 predecoder lines. Each wordline is the AND of one line from each of the four predecoders.
- R6: Every address drives the same wordline in both groupings, and that wordline is the one a direct full-width decoder would select.
- R7: While `rst_n` is 0, `wordline` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Decode enable; 0 forces every wordline low |
| row_addr | input | ADDR_W (8) | Row address |
| wordline | output | 2**ADDR_W (256) | Registered one-hot wordline enables |

## Verification
The bench builds two copies of the block side by side with the default 8-bit address. One uses `PREDEC_BITS` = 4 (two groups) and the other uses `PREDEC_BITS` = 2 (four groups). Both copies receive the same stimulus. This lets every one of the 256 addresses be checked against the expected index in both groupings, and lets the two outputs be compared with each other on every cycle. The stimulus also covers the disabled cycles, a reset asserted in the middle of the run, and a run of pseudo-random addresses with the enable toggling.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    // Selects the value of predecode field g (width w) inside a wordline index k.
    function automatic int field_of(input int k, input int g, input int w);
        return (k >> (g * w)) % (1 << w);
    endfunction

endpackage

// File: rtl/rowdec_predec.sv
module rowdec_predec #(
    parameter int IN_W = 4,
    localparam int LINES = 1 << IN_W
) (
    input  logic             enable,
    input  logic [IN_W-1:0]  field,
    output logic [LINES-1:0] lines
);

    always_comb begin
        lines = '0;
        if (enable) begin
            lines[field] = 1'b1;
        end
    end

    // When enabled, exactly one predecoded line is active.
    always_comb begin
        if (enable) begin
            assert_predec_onehot_R1: assert ($onehot(lines));
        end
    end

endmodule

// File: rtl/rowdec_and_plane.sv
module rowdec_and_plane #(
    parameter int GRP_W      = 4,
    parameter int NUM_GROUPS = 2,
    localparam int LINES     = 1 << GRP_W,
    localparam int NUM_WL    = 1 << (GRP_W * NUM_GROUPS)
) (
    input  logic [NUM_GROUPS*LINES-1:0] pre,
    output logic [NUM_WL-1:0]           wl
);

    for (genvar k = 0; k < NUM_WL; k++) begin : g_wl
        logic [NUM_GROUPS-1:0] terms;
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_term
            assign terms[g] = pre[g*LINES + rowdec_pkg::field_of(k, g, GRP_W)];
        end
        assign wl[k] = &terms;
    end

    // The shared predecode lines must never light two wordlines at once.
    always_comb begin
        assert_plane_onehot_R2: assert ($onehot0(wl));
    end

endmodule

// File: rtl/rowdec_wl_top.sv
module rowdec_wl_top #(
    parameter int ADDR_W      = 8,
    parameter int PREDEC_BITS = 4,
    localparam int NUM_GROUPS = ADDR_W / PREDEC_BITS,
    localparam int LINES      = 1 << PREDEC_BITS,
    localparam int NUM_WL     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic [ADDR_W-1:0] row_addr,
    output logic [NUM_WL-1:0] wordline
);

    typedef struct packed {
        logic [NUM_WL-1:0] wl;
    } wl_state_t;

    wl_state_t state_d, state_q;

    logic [NUM_GROUPS*LINES-1:0] pre_lines;
    logic [NUM_WL-1:0]           wl_comb;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_predec
        rowdec_predec #(.IN_W(PREDEC_BITS)) predec_i (
            .enable (dec_en),
            .field  (row_addr[g*PREDEC_BITS +: PREDEC_BITS]),
            .lines  (pre_lines[g*LINES +: LINES])
        );
    end

    rowdec_and_plane #(
        .GRP_W      (PREDEC_BITS),
        .NUM_GROUPS (NUM_GROUPS)
    ) plane_i (
        .pre (pre_lines),
        .wl  (wl_comb)
    );

    always_comb begin
        state_d    = state_q;
        state_d.wl = wl_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wordline = state_q.wl;

    // Marks that one full clock has passed since reset so $past looks at valid cycles.
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
        end
    end

    assert_wl_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wordline));

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(dec_en)) |-> (wordline == '0));

    assert_addr_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(dec_en)) |-> wordline[$past(row_addr)]);

endmodule

// File: tb/rowdec_wl_top_tb_top.sv
module rowdec_wl_top_tb_top;

    localparam int AW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_en = 1'b0;
    logic [AW-1:0] row_addr = '0;
    logic [NW-1:0] wl_two, wl_four;

    int checks = 0;
    int errors = 0;
    int exp_idx = -1;
    bit in_reset = 1'b1;

    always #2.5 clk = ~clk;

    // Two groups of 4 bits
    rowdec_wl_top #(.ADDR_W(AW), .PREDEC_BITS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .row_addr(row_addr), .wordline(wl_two)
    );

    // Four groups of 2 bits
    rowdec_wl_top #(.ADDR_W(AW), .PREDEC_BITS(2)) dut_quad_i (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .row_addr(row_addr), .wordline(wl_four)
    );

    // Behavioural reference: index of the single expected wordline, -1 for none.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_idx <= -1;
        else        exp_idx <= dec_en ? int'(row_addr) : -1;
    end

    function automatic logic [NW-1:0] vec_of(input int idx);
        logic [NW-1:0] v = '0;
        if (idx >= 0) v[idx] = 1'b1;
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compare_now();
        logic [NW-1:0] e = vec_of(exp_idx);
        string tag_two, tag_four;
        if (in_reset)          begin tag_two = "R7"; tag_four = "R7"; end
        else if (exp_idx < 0)  begin tag_two = "R3"; tag_four = "R3"; end
        else                   begin tag_two = "R1/R4"; tag_four = "R1/R5"; end
        check_vec(tag_two, wl_two, e);
        check_vec(tag_four, wl_four, e);
        // R2: at most one wordline
        checks++;
        if ($countones(wl_two) > 1 || $countones(wl_four) > 1) begin
            errors++;
            $display("FAIL R2 act=%0d/%0d exp<=1", $countones(wl_two), $countones(wl_four));
        end
        // R6: both groupings agree
        check_vec("R6", wl_four, wl_two);
    endtask

    task automatic step(input logic en, input logic [AW-1:0] a);
        @(negedge clk);
        compare_now();
        dec_en   = en;
        row_addr = a;
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) step(1'b0, 8'h00);
        step(1'b1, 8'h3C);          // en high during reset: R7 must still hold zero
        step(1'b1, 8'h3C);
        rst_n    = 1'b1;
        in_reset = 1'b0;
        // full sweep, both groupings: R1 R4 R5 R6
        for (int a = 0; a < NW; a++) step(1'b1, 8'(a));
        step(1'b1, 8'd254);
        step(1'b1, 8'd255);
        step(1'b1, 8'd0);
        // disabled with varied addresses: R3
        step(1'b0, 8'hFF);
        step(1'b0, 8'h11);
        step(1'b1, 8'h80);
        step(1'b0, 8'h80);
        // pseudo-random addresses with toggling enable
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[3], lfsr);
        end
        // mid-run reset: R7
        @(negedge clk);
        rst_n    = 1'b0;
        in_reset = 1'b1;
        step(1'b1, 8'h42);
        step(1'b1, 8'h43);
        rst_n    = 1'b1;
        in_reset = 1'b0;
        step(1'b1, 8'h07);
        step(1'b1, 8'hF0);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule